// File: doc/BRIEF.md
# NAND Command-Cycle Sequencer

This block turns a queue of 32-bit command words into NAND flash bus cycles. Software, or a descriptor engine, pushes words into a small command queue. The sequencer takes them one at a time and drives the command-latch and address-latch enables, the write and read strobes, and the bidirectional data byte. It also observes the device's ready/busy pin.

Each word names a cycle kind in a 2-bit field:
- address byte
- command byte
- data write burst
- data read burst

For data bursts, the write bytes come from a DMA byte source, and the read bytes go to a DMA byte sink. Three flag bits control how each word ends:
- wait for the device to report ready before the word counts as finished;
- mark the word as the last one of an operation;
- raise the interrupt line when the word finishes.

Results are kept in a 13-bit sticky status vector. Each bit is cleared by writing a one to its position on the clear port. A malformed word sets the error bit and freezes the queue until software clears that bit. The low and high strobe widths are set at run time through two input ports.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset, we_n and re_n are 1, cle, ale and dq_oe are 0, status is all zero and irq is 0.
- R2: A word with bits 17:16 = 1 (command) produces one we_n low pulse lasting strobe_lo+1 clock cycles. During that pulse cle is 1, ale is 0, and dq_out carries bits 7:0 of the word on the rising edge of we_n.
- R3: A word with bits 17:16 = 0 (address) produces one we_n pulse with ale = 1, cle = 0 and dq_out = bits 7:0 of the word on the rising edge.
- R4: A word with bits 17:16 = 2 (write) and bits 11:0 = N-1 produces N we_n pulses. Each pulse takes one byte from tx_data with a one-cycle tx_pop. The bytes leave on dq_out in the order they were taken. When the burst finishes, status bit 6 is set.
- R5: A word with bits 17:16 = 3 (read) and bits 11:0 = N-1 produces N re_n pulses, with dq_oe at 0. Each pulse captures dq_in in its last low cycle and presents that byte on rx_data with a one-cycle rx_push. When the burst finishes, status bit 7 is set.
- R6: When bit 19 of a word is set, the word does not finish, and the next word does not start, until rb_n is 1.
- R7: When bit 18 of a word is set, status bit 9 (command done) is set once the word finishes, including any ready wait. A word without bit 18 leaves bit 9 clear.
- R8: When bit 13 of a word is set, irq goes to 1 once the word finishes. irq returns to 0 when bit 9 is written to the clear port.
- R9: A word with any of bits 31:20 nonzero makes no bus cycle and sets status bit 11 (command error). While bit 11 is set, queued words stay queued. Once bit 11 is cleared, they run in order.
- R10: A pulse on clr_wr clears exactly the status bits that are one in clr_wdata and leaves the others unchanged. If a bit is set and cleared in the same cycle, the set wins.
- R11: Between consecutive strobe pulses of one burst, the strobe stays high for strobe_hi+1 cycles.
- R12: Words run in push order. cmd_full is 1 when the queue holds QDEPTH words, and a push while cmd_full is 1 is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Push one command word |
| cmd_wdata | input | 32 | Command word |
| cmd_full | output | 1 | Command queue full |
| clr_wr | input | 1 | Status clear strobe |
| clr_wdata | input | 13 | Status bits to clear (write one to clear) |
| status | output | 13 | Sticky status vector |
| irq | output | 1 | Completion interrupt |
| strobe_lo | input | 4 | Strobe low width minus one, in clocks |
| strobe_hi | input | 4 | Strobe high width minus one, in clocks |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | 8 | Data byte driven to flash |
| dq_oe | output | 1 | Data bus output enable |
| dq_in | input | 8 | Data byte from flash |
| rb_n | input | 1 | Ready/busy, 1 means ready |
| tx_data | input | 8 | Next byte from the DMA source |
| tx_pop | output | 1 | Byte taken from tx_data |
| rx_data | output | 8 | Byte captured for the DMA sink |
| rx_push | output | 1 | rx_data is valid |

## Verification
The hardest state to reach is a full command queue. The sequencer normally drains the queue faster than the bench can fill it. To fill it, the bench holds rb_n low, pushes a command word carrying the ready-wait flag, and waits for that word to be taken. The engine is now parked waiting for ready, so further pushes fill the queue and the extra push is discarded. The bench then releases rb_n and counts strobe pulses to confirm that exactly the queued words ran. The error freeze is reached in a similar way: a malformed word is queued ahead of a valid one, and the bench confirms that the valid word runs only after the error bit is cleared.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int STW = 13;
  localparam int ST_TXDONE  = 6;
  localparam int ST_RXDONE  = 7;
  localparam int ST_CMDDONE = 9;
  localparam int ST_CMDERR  = 11;

  typedef enum logic [1:0] {
    CY_ADDR = 2'd0,
    CY_CMD  = 2'd1,
    CY_WR   = 2'd2,
    CY_RD   = 2'd3
  } cycle_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOW  = 2'd1,
    S_HIGH = 2'd2,
    S_WAIT = 2'd3
  } seq_state_t;
endpackage

// File: rtl/nand_seq_fifo.sv
module nand_seq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp_q];

  always_comb begin
    cnt_d = cnt_q;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (do_push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  // R12
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R12
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);
endmodule

// File: rtl/nand_seq_engine.sv
module nand_seq_engine
  import nand_seq_pkg::*;
#(
  parameter int PW   = 4,
  parameter int LENW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           q_empty,
  input  logic [31:0]    q_data,
  output logic           q_pop,
  input  logic           err_i,
  input  logic [PW-1:0]  strobe_lo,
  input  logic [PW-1:0]  strobe_hi,
  output logic           cle,
  output logic           ale,
  output logic           we_n,
  output logic           re_n,
  output logic [7:0]     dq_out,
  output logic           dq_oe,
  input  logic [7:0]     dq_in,
  input  logic           rb_n,
  input  logic [7:0]     tx_data,
  output logic           tx_pop,
  output logic [7:0]     rx_data,
  output logic           rx_push,
  output logic [STW-1:0] set_vec,
  output logic           irq_set
);
  seq_state_t      state_q, state_d;
  logic [PW-1:0]   cnt_q, cnt_d;
  logic [LENW-1:0] left_q, left_d;
  cycle_t          kind_q, kind_d;
  logic            wfr_q, last_q, iwc_q;
  logic [7:0]      dq_q, dq_d;
  logic            rxp_q;
  logic [7:0]      rxd_q;

  logic start, illegal, launch, low_end, high_end, more, next_byte, finish;
  cycle_t in_kind;

  assign in_kind   = cycle_t'(q_data[17:16]);
  assign illegal   = |q_data[31:20];
  assign start     = (state_q == S_IDLE) && !q_empty && !err_i;
  assign launch    = start && !illegal;
  assign q_pop     = start;
  assign low_end   = (state_q == S_LOW) && (cnt_q == '0);
  assign high_end  = (state_q == S_HIGH) && (cnt_q == '0);
  assign more      = (left_q != '0) && kind_q[1];
  assign next_byte = high_end && more;
  assign finish    = (high_end && !more && !wfr_q) || ((state_q == S_WAIT) && rb_n);
  assign tx_pop    = (launch && in_kind == CY_WR) || (next_byte && kind_q == CY_WR);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    left_d  = left_q;
    kind_d  = kind_q;
    dq_d    = dq_q;
    case (state_q)
      S_IDLE: if (launch) begin
        state_d = S_LOW;
        cnt_d   = strobe_lo;
        kind_d  = in_kind;
        left_d  = in_kind[1] ? q_data[LENW-1:0] : '0;
        dq_d    = (in_kind == CY_WR) ? tx_data : q_data[7:0];
      end
      S_LOW: begin
        if (low_end) begin
          state_d = S_HIGH;
          cnt_d   = strobe_hi;
        end else cnt_d = cnt_q - 1'b1;
      end
      S_HIGH: begin
        if (next_byte) begin
          state_d = S_LOW;
          cnt_d   = strobe_lo;
          left_d  = left_q - 1'b1;
          if (kind_q == CY_WR) dq_d = tx_data;
        end else if (high_end) state_d = wfr_q ? S_WAIT : S_IDLE;
        else cnt_d = cnt_q - 1'b1;
      end
      S_WAIT: if (rb_n) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      left_q  <= '0;
      kind_q  <= CY_ADDR;
      wfr_q   <= 1'b0;
      last_q  <= 1'b0;
      iwc_q   <= 1'b0;
      dq_q    <= '0;
      rxp_q   <= 1'b0;
      rxd_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      left_q  <= left_d;
      kind_q  <= kind_d;
      dq_q    <= dq_d;
      if (launch) begin
        wfr_q  <= q_data[19];
        last_q <= q_data[18];
        iwc_q  <= q_data[13];
      end
      rxp_q <= low_end && (kind_q == CY_RD);
      if (low_end && (kind_q == CY_RD)) rxd_q <= dq_in;
    end
  end

  logic busy;
  assign busy    = (state_q == S_LOW) || (state_q == S_HIGH);
  assign cle     = busy && (kind_q == CY_CMD);
  assign ale     = busy && (kind_q == CY_ADDR);
  assign we_n    = !((state_q == S_LOW) && (kind_q != CY_RD));
  assign re_n    = !((state_q == S_LOW) && (kind_q == CY_RD));
  assign dq_oe   = busy && (kind_q != CY_RD);
  assign dq_out  = dq_q;
  assign rx_data = rxd_q;
  assign rx_push = rxp_q;

  always_comb begin
    set_vec = '0;
    set_vec[ST_CMDERR]  = start && illegal;
    set_vec[ST_CMDDONE] = finish && last_q;
    set_vec[ST_TXDONE]  = finish && (kind_q == CY_WR);
    set_vec[ST_RXDONE]  = finish && (kind_q == CY_RD);
  end
  assign irq_set = finish && iwc_q;

  // R2
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  // R5
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !dq_oe);
  // R6
  ready_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT && !rb_n) |=> (state_q == S_WAIT));
  // R9
  halt_on_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_i |-> !q_pop);
endmodule

// File: rtl/nand_seq_status.sv
module nand_seq_status
  import nand_seq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [STW-1:0] set_vec,
  input  logic           irq_set,
  input  logic           clr_wr,
  input  logic [STW-1:0] clr_wdata,
  output logic [STW-1:0] status,
  output logic           irq
);
  logic [STW-1:0] st_q, st_d, clr_mask;
  logic           irq_q, irq_d;

  assign clr_mask = clr_wr ? clr_wdata : '0;

  always_comb begin
    st_d  = (st_q & ~clr_mask) | set_vec;
    irq_d = (irq_q & ~clr_mask[ST_CMDDONE]) | irq_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= irq_d;
    end
  end

  assign status = st_q;
  assign irq    = irq_q;

  // R10
  sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status) & ~$past(clr_mask)) & ~status) == '0));
  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_mask[ST_CMDDONE]) |=> irq);
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int PW     = 4,
  parameter int LENW   = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_wr,
  input  logic [31:0]    cmd_wdata,
  output logic           cmd_full,
  input  logic           clr_wr,
  input  logic [STW-1:0] clr_wdata,
  output logic [STW-1:0] status,
  output logic           irq,
  input  logic [PW-1:0]  strobe_lo,
  input  logic [PW-1:0]  strobe_hi,
  output logic           cle,
  output logic           ale,
  output logic           we_n,
  output logic           re_n,
  output logic [7:0]     dq_out,
  output logic           dq_oe,
  input  logic [7:0]     dq_in,
  input  logic           rb_n,
  input  logic [7:0]     tx_data,
  output logic           tx_pop,
  output logic [7:0]     rx_data,
  output logic           rx_push
);
  logic           q_empty, q_pop, irq_set;
  logic [31:0]    q_data;
  logic [STW-1:0] set_vec;

  nand_seq_fifo #(.W(32), .DEPTH(QDEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(cmd_wr), .wdata(cmd_wdata),
    .pop(q_pop), .rdata(q_data), .empty(q_empty), .full(cmd_full)
  );

  nand_seq_engine #(.PW(PW), .LENW(LENW)) u_engine (
    .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_data(q_data), .q_pop(q_pop),
    .err_i(status[ST_CMDERR]), .strobe_lo(strobe_lo), .strobe_hi(strobe_hi),
    .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .dq_out(dq_out), .dq_oe(dq_oe),
    .dq_in(dq_in), .rb_n(rb_n), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_data(rx_data), .rx_push(rx_push), .set_vec(set_vec), .irq_set(irq_set)
  );

  nand_seq_status u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .irq_set(irq_set),
    .clr_wr(clr_wr), .clr_wdata(clr_wdata), .status(status), .irq(irq)
  );
endmodule

// File: tb/nand_cycle_seq_test.sv
module nand_cycle_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        cmd_full;
  logic        clr_wr = 1'b0;
  logic [12:0] clr_wdata = '0;
  logic [12:0] status;
  logic        irq;
  logic [3:0]  strobe_lo = 4'd3;
  logic [3:0]  strobe_hi = 4'd2;
  logic        cle, ale, we_n, re_n, dq_oe, rb_n = 1'b1;
  logic [7:0]  dq_out, dq_in, tx_data, rx_data;
  logic        tx_pop, rx_push;

  int checks = 0, fails = 0;
  int we_cnt = 0, rd_cnt = 0, tx_cnt = 0, rx_cnt = 0;
  int lo_run = 0, hi_run = 0, last_lo = 0, last_hi = 0;
  logic [7:0] dq_log [64];
  logic       cle_log [64];
  logic       ale_log [64];
  logic [7:0] rx_log [64];

  always #2 clk = ~clk;

  nand_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_full(cmd_full),
    .clr_wr(clr_wr), .clr_wdata(clr_wdata), .status(status), .irq(irq),
    .strobe_lo(strobe_lo), .strobe_hi(strobe_hi), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .rb_n(rb_n),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_data(rx_data), .rx_push(rx_push)
  );

  assign tx_data = 8'h30 + 8'(tx_cnt);
  assign dq_in   = 8'hA0 + 8'(rd_cnt);

  always @(posedge we_n) if (rst_n) begin
    dq_log[we_cnt % 64]  = dq_out;
    cle_log[we_cnt % 64] = cle;
    ale_log[we_cnt % 64] = ale;
    we_cnt++;
  end
  always @(posedge re_n) if (rst_n) rd_cnt++;
  always @(posedge clk) begin
    if (tx_pop) tx_cnt <= tx_cnt + 1;
    if (rx_push) begin rx_log[rx_cnt % 64] <= rx_data; rx_cnt <= rx_cnt + 1; end
  end
  always @(posedge clk) begin
    if (!we_n) begin
      if (hi_run != 0) last_hi = hi_run;
      hi_run = 0; lo_run++;
    end else begin
      if (lo_run != 0) last_lo = lo_run;
      lo_run = 0; hi_run++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic clear(input logic [12:0] m);
    @(negedge clk); clr_wr = 1'b1; clr_wdata = m;
    @(negedge clk); clr_wr = 1'b0; clr_wdata = '0;
  endtask

  task automatic settle();
    repeat (120) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(we_n && re_n && !cle && !ale && !dq_oe, "R1 strobes", {we_n, re_n, cle, ale, dq_oe}, 5'b11000);
    chk(status == 0 && !irq, "R1 status", {irq, status}, 0);
  endtask

  task automatic t_command();
    int b = we_cnt;
    push(32'h0001_0070);
    settle();
    chk(we_cnt == b + 1, "R2 pulses", we_cnt - b, 1);
    chk(cle_log[b % 64] && !ale_log[b % 64] && dq_log[b % 64] == 8'h70, "R2 latch/byte",
        {cle_log[b % 64], ale_log[b % 64], dq_log[b % 64]}, {2'b10, 8'h70});
    chk(last_lo == 4, "R2 low width", last_lo, 4);
    chk(!status[9], "R7 no last flag", status, 0);
  endtask

  task automatic t_address();
    int b = we_cnt;
    push(32'h0004_0012);
    settle();
    chk(ale_log[b % 64] && !cle_log[b % 64] && dq_log[b % 64] == 8'h12, "R3 address",
        {ale_log[b % 64], cle_log[b % 64], dq_log[b % 64]}, {2'b10, 8'h12});
    chk(status[9], "R7 done set", status, 13'h200);
    clear(13'h1FFF);
  endtask

  task automatic t_write();
    int b = we_cnt;
    int t = tx_cnt;
    push(32'h0006_0002);
    settle();
    chk(we_cnt == b + 3 && tx_cnt == t + 3, "R4 pulses/pops", we_cnt - b, 3);
    for (int i = 0; i < 3; i++)
      chk(dq_log[(b + i) % 64] == 8'h30 + 8'(t + i), "R4 byte", dq_log[(b + i) % 64], 8'h30 + 8'(t + i));
    chk(last_hi == 3, "R11 high width", last_hi, 3);
    chk(status == 13'h240, "R4 tx done", status, 13'h240);
    clear(13'h040);
    chk(status == 13'h200, "R10 partial clear", status, 13'h200);
    clear(13'h1FFF);
  endtask

  task automatic t_read();
    int r = rd_cnt;
    int x = rx_cnt;
    int b = we_cnt;
    push(32'h0003_0001);
    settle();
    chk(rx_cnt == x + 2 && we_cnt == b, "R5 count", rx_cnt - x, 2);
    for (int i = 0; i < 2; i++)
      chk(rx_log[(x + i) % 64] == 8'hA0 + 8'(r + i), "R5 byte", rx_log[(x + i) % 64], 8'hA0 + 8'(r + i));
    chk(status == 13'h080, "R5 rx done", status, 13'h080);
    clear(13'h1FFF);
  endtask

  task automatic t_irq();
    push(32'h0005_20FF);
    settle();
    chk(irq == 1'b1, "R8 irq set", irq, 1);
    clear(13'h200);
    chk(irq == 1'b0, "R8 irq cleared", irq, 0);
  endtask

  task automatic t_ready();
    int b = we_cnt;
    @(negedge clk); rb_n = 1'b0;
    push(32'h000D_0030);
    push(32'h0001_0031);
    settle();
    chk(we_cnt == b + 1 && !status[9], "R6 held busy", we_cnt - b, 1);
    @(negedge clk); rb_n = 1'b1;
    settle();
    chk(we_cnt == b + 2 && status[9], "R6 released", we_cnt - b, 2);
    clear(13'h1FFF);
  endtask

  task automatic t_error();
    int b = we_cnt;
    push(32'h0010_0001);
    push(32'h0001_0055);
    settle();
    chk(status[11] && we_cnt == b, "R9 halted", {status[11], 8'(we_cnt - b)}, 9'h100);
    clear(13'h800);
    settle();
    chk(we_cnt == b + 1 && dq_log[b % 64] == 8'h55, "R9 resumed", dq_log[b % 64], 8'h55);
  endtask

  task automatic t_full();
    int b = we_cnt;
    @(negedge clk); rb_n = 1'b0;
    push(32'h0009_0001);
    repeat (20) @(negedge clk);
    for (int i = 0; i < 4; i++) push(32'h0001_0010 + 32'(i));
    chk(cmd_full, "R12 full", cmd_full, 1);
    push(32'h0001_00EE);
    @(negedge clk); rb_n = 1'b1;
    repeat (200) @(negedge clk);
    chk(we_cnt == b + 5, "R12 drop", we_cnt - b, 5);
    chk(dq_log[(b + 4) % 64] == 8'h13, "R12 order", dq_log[(b + 4) % 64], 8'h13);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_command();
    t_address();
    t_write();
    t_read();
    t_irq();
    t_ready();
    t_error();
    t_full();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule